// File: doc/BRIEF.md
# Chained-Bucket Flow Session Resolver

This engine takes one packet flow key at a time and resolves it against a session table in external memory. The table is a hash table. A reflected CRC-32 of the key selects a bucket slot, and every slot holds a complete table entry. Entries that collide with the slot are linked behind it through a pointer field. The engine reads the slot and compares the stored key against the probe key. When the keys differ, it follows the link and reads again, one memory read per link, until an entry matches, the chain ends, or a configurable walk limit is reached.

On a match the engine returns the entry's state and action and writes the entry back with its state advanced by one. A miss creates no entry. The engine only reports the miss, so the packet can be sent on to a separate classification path. A walk that stops at the limit is reported as a miss with an overflow flag. The memory port accepts requests through a valid/ready handshake, and read data returns after a latency that can vary. The engine does not accept a new key until the previous result has been taken.

Top module: `session_lookup`

## Requirements
- R1: The first read of every lookup goes to address `crc[IDX_W-1:0]`, zero-extended to `PTR_W` bits. Here `crc` is the reflected CRC-32 of the key: polynomial 0xEDB88320, register preset to all ones, key bits fed least-significant first, result inverted at the end.
- R2: A table word is, from its most significant bit down: a valid bit, the key (`KEY_W`), the state (`STATE_W`), the action (`ACT_W`), and the next pointer (`PTR_W`) in the least significant bits. A next pointer of zero ends a chain.
- R3: A hit occurs when a read returns a word whose valid bit is set and whose key equals the probe key. The result then has `out_hit`=1 and `out_overflow`=0, and carries that word's state and action as read.
- R4: A hit causes exactly one memory write, to the address of the matching word. The written word equals the read word except for the state field, which is incremented by one and saturates at all ones.
- R5: A word that does not match, is valid, and has a non-zero next pointer causes the next read to go to that pointer. `out_reads` reports the number of reads the lookup made.
- R6: A miss occurs when the engine reads an invalid word, or a valid non-matching word whose next pointer is zero. The result then has `out_hit`=0, `out_overflow`=0, state and action zero, and no write is issued.
- R7: If the `MAX_DEPTH`-th read returns a valid, non-matching word whose next pointer is non-zero, the walk stops. The result is `out_hit`=0 and `out_overflow`=1 with `out_reads`=`MAX_DEPTH`, and no write is issued.
- R8: `in_ready` is low from the cycle after a key is accepted until the cycle after its result is accepted. `out_valid` and all result fields hold steady while `out_ready` is low.
- R9: A memory request keeps its valid, address, write flag and data unchanged until it is accepted. No request is raised while a read response is still owed.
- R10: After reset, `in_ready`=1, `out_valid`=0 and `mem_req_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A key is offered |
| in_ready | output | 1 | The engine is idle and takes the key |
| in_key | input | KEY_W | Flow key built from the packet header |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | The consumer takes the result |
| out_hit | output | 1 | A matching entry was found |
| out_overflow | output | 1 | The walk stopped at the depth limit |
| out_state | output | STATE_W | State of the matched entry, before its update |
| out_action | output | ACT_W | Action of the matched entry |
| out_reads | output | $clog2(MAX_DEPTH+1) | Number of table reads this lookup used |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | PTR_W | Word address |
| mem_req_wdata | output | 1+KEY_W+STATE_W+ACT_W+PTR_W | Write data |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | 1+KEY_W+STATE_W+ACT_W+PTR_W | Read data |

## Verification
The bench builds the engine with a 32-bit key, an 18-bit pointer, and a walk limit of 4. With a limit this small, overflow and a hit landing exactly on the last permitted read take only a few chain links to build. Chain entries are placed above the 64K bucket region, so link addresses never collide with bucket slots. The memory model varies both its request acceptance and its read latency, so every handshake hold and every wait for a response is exercised. The tests also cover state saturation, a hit on a later lookup that observes the earlier write-back, and a long hold on the result output.

// File: rtl/session_pkg.sv
package session_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RD,
        PH_WAIT,
        PH_WR,
        PH_DONE
    } phase_e;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

endpackage

// File: rtl/session_hash.sv
module session_hash #(
    parameter int KEY_W = 104,
    parameter int IDX_W = 16
) (
    input  logic [KEY_W-1:0] key,
    output logic [IDX_W-1:0] idx
);
    import session_pkg::*;

    logic [31:0] stage [KEY_W+1];

    assign stage[0] = 32'hFFFF_FFFF;

    // One shift-and-conditional-xor step per key bit, LSB first.
    for (genvar b = 0; b < KEY_W; b++) begin : g_bit
        logic fb;
        assign fb = stage[b][0] ^ key[b];
        assign stage[b+1] = (stage[b] >> 1) ^ (fb ? CRC_POLY_REFL : 32'h0);
    end

    logic [31:0] crc_final;
    assign crc_final = ~stage[KEY_W];
    assign idx = crc_final[IDX_W-1:0];

endmodule

// File: rtl/session_entry.sv
module session_entry #(
    parameter int KEY_W   = 104,
    parameter int STATE_W = 8,
    parameter int ACT_W   = 4,
    parameter int PTR_W   = 20,
    localparam int ENT_W  = 1 + KEY_W + STATE_W + ACT_W + PTR_W
) (
    input  logic [ENT_W-1:0]   word,
    input  logic [KEY_W-1:0]   probe_key,
    output logic               ent_valid,
    output logic               ent_match,
    output logic               ent_last,
    output logic [STATE_W-1:0] ent_state,
    output logic [ACT_W-1:0]   ent_action,
    output logic [PTR_W-1:0]   ent_next,
    output logic [ENT_W-1:0]   upd_word
);
    localparam int NXT_LO = 0;
    localparam int ACT_LO = PTR_W;
    localparam int ST_LO  = ACT_LO + ACT_W;
    localparam int KEY_LO = ST_LO + STATE_W;
    localparam int VLD_B  = KEY_LO + KEY_W;

    logic [KEY_W-1:0]   ent_key;
    logic [STATE_W-1:0] next_state;

    assign ent_valid  = word[VLD_B];
    assign ent_key    = word[KEY_LO +: KEY_W];
    assign ent_state  = word[ST_LO +: STATE_W];
    assign ent_action = word[ACT_LO +: ACT_W];
    assign ent_next   = word[NXT_LO +: PTR_W];
    assign ent_match  = ent_valid && (ent_key == probe_key);
    assign ent_last   = (ent_next == '0);

    always_comb begin
        if (&ent_state) next_state = ent_state;
        else            next_state = ent_state + STATE_W'(1);
        upd_word = word;
        upd_word[ST_LO +: STATE_W] = next_state;
    end

endmodule

// File: rtl/session_lookup.sv
module session_lookup #(
    parameter int KEY_W     = 104,
    parameter int IDX_W     = 16,
    parameter int PTR_W     = 20,
    parameter int STATE_W   = 8,
    parameter int ACT_W     = 4,
    parameter int MAX_DEPTH = 8,
    localparam int ENT_W    = 1 + KEY_W + STATE_W + ACT_W + PTR_W,
    localparam int CNT_W    = $clog2(MAX_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [KEY_W-1:0]   in_key,
    output logic               out_valid,
    input  logic               out_ready,
    output logic               out_hit,
    output logic               out_overflow,
    output logic [STATE_W-1:0] out_state,
    output logic [ACT_W-1:0]   out_action,
    output logic [CNT_W-1:0]   out_reads,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic               mem_req_write,
    output logic [PTR_W-1:0]   mem_req_addr,
    output logic [ENT_W-1:0]   mem_req_wdata,
    input  logic               mem_rsp_valid,
    input  logic [ENT_W-1:0]   mem_rsp_rdata
);
    import session_pkg::*;

    typedef struct packed {
        phase_e             phase;
        logic [KEY_W-1:0]   key;
        logic [PTR_W-1:0]   ptr;
        logic [CNT_W-1:0]   reads;
        logic               hit;
        logic               ovf;
        logic [STATE_W-1:0] state;
        logic [ACT_W-1:0]   action;
        logic [ENT_W-1:0]   wword;
    } walk_t;

    walk_t walk_d, walk_q;

    logic [IDX_W-1:0]   bucket_idx;
    logic               ent_valid, ent_match, ent_last;
    logic [STATE_W-1:0] ent_state;
    logic [ACT_W-1:0]   ent_action;
    logic [PTR_W-1:0]   ent_next;
    logic [ENT_W-1:0]   upd_word;

    session_hash #(
        .KEY_W(KEY_W),
        .IDX_W(IDX_W)
    ) u_hash (
        .key(in_key),
        .idx(bucket_idx)
    );

    session_entry #(
        .KEY_W  (KEY_W),
        .STATE_W(STATE_W),
        .ACT_W  (ACT_W),
        .PTR_W  (PTR_W)
    ) u_entry (
        .word      (mem_rsp_rdata),
        .probe_key (walk_q.key),
        .ent_valid (ent_valid),
        .ent_match (ent_match),
        .ent_last  (ent_last),
        .ent_state (ent_state),
        .ent_action(ent_action),
        .ent_next  (ent_next),
        .upd_word  (upd_word)
    );

    always_comb begin
        walk_d        = walk_q;
        in_ready      = 1'b0;
        out_valid     = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = walk_q.ptr;
        mem_req_wdata = walk_q.wword;

        unique case (walk_q.phase)
            PH_IDLE: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    walk_d.key   = in_key;
                    walk_d.ptr   = PTR_W'(bucket_idx);
                    walk_d.reads = '0;
                    walk_d.phase = PH_RD;
                end
            end
            PH_RD: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) begin
                    walk_d.reads = walk_q.reads + CNT_W'(1);
                    walk_d.phase = PH_WAIT;
                end
            end
            PH_WAIT: begin
                if (mem_rsp_valid) begin
                    if (ent_match) begin
                        walk_d.hit    = 1'b1;
                        walk_d.ovf    = 1'b0;
                        walk_d.state  = ent_state;
                        walk_d.action = ent_action;
                        walk_d.wword  = upd_word;
                        walk_d.phase  = PH_WR;
                    end else begin
                        walk_d.hit    = 1'b0;
                        walk_d.state  = '0;
                        walk_d.action = '0;
                        if (!ent_valid || ent_last) begin
                            walk_d.ovf   = 1'b0;
                            walk_d.phase = PH_DONE;
                        end else if (walk_q.reads == CNT_W'(MAX_DEPTH)) begin
                            walk_d.ovf   = 1'b1;
                            walk_d.phase = PH_DONE;
                        end else begin
                            walk_d.ptr   = ent_next;
                            walk_d.phase = PH_RD;
                        end
                    end
                end
            end
            PH_WR: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                if (mem_req_ready) walk_d.phase = PH_DONE;
            end
            PH_DONE: begin
                out_valid = 1'b1;
                if (out_ready) walk_d.phase = PH_IDLE;
            end
            default: walk_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_q       <= '0;
            walk_q.phase <= PH_IDLE;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign out_hit      = walk_q.hit;
    assign out_overflow = walk_q.ovf;
    assign out_state    = walk_q.state;
    assign out_action   = walk_q.action;
    assign out_reads    = walk_q.reads;

endmodule

// File: rtl/session_lookup_chk.sv
module session_lookup_chk #(
    parameter int KEY_W     = 104,
    parameter int PTR_W     = 20,
    parameter int STATE_W   = 8,
    parameter int ACT_W     = 4,
    parameter int MAX_DEPTH = 8,
    localparam int ENT_W    = 1 + KEY_W + STATE_W + ACT_W + PTR_W,
    localparam int CNT_W    = $clog2(MAX_DEPTH + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_ready,
    input logic               out_valid,
    input logic               out_ready,
    input logic               out_hit,
    input logic               out_overflow,
    input logic [STATE_W-1:0] out_state,
    input logic [ACT_W-1:0]   out_action,
    input logic [CNT_W-1:0]   out_reads,
    input logic               mem_req_valid,
    input logic               mem_req_ready,
    input logic               mem_req_write,
    input logic [PTR_W-1:0]   mem_req_addr,
    input logic [ENT_W-1:0]   mem_req_wdata,
    input logic               mem_rsp_valid
);
    logic rsp_owed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_owed <= 1'b0;
        else if (mem_req_valid && mem_req_ready && !mem_req_write) rsp_owed <= 1'b1;
        else if (mem_rsp_valid) rsp_owed <= 1'b0;
    end

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_write) && $stable(mem_req_wdata));

    assert_no_req_owed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_owed |-> !mem_req_valid);

    assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_hit) && $stable(out_overflow)
            && $stable(out_state) && $stable(out_action) && $stable(out_reads));

    assert_one_at_a_time_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    assert_write_then_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_ready && mem_req_write |=> out_valid && out_hit);

    assert_overflow_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_overflow |-> !out_hit && out_reads == CNT_W'(MAX_DEPTH));

    assert_walk_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_reads != '0 && out_reads <= CNT_W'(MAX_DEPTH));

endmodule

bind session_lookup session_lookup_chk #(
    .KEY_W    (KEY_W),
    .PTR_W    (PTR_W),
    .STATE_W  (STATE_W),
    .ACT_W    (ACT_W),
    .MAX_DEPTH(MAX_DEPTH)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_hit      (out_hit),
    .out_overflow (out_overflow),
    .out_state    (out_state),
    .out_action   (out_action),
    .out_reads    (out_reads),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write),
    .mem_req_addr (mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/session_lookup_test.sv
`timescale 1ns/1ps
module session_lookup_test;
    localparam int KW = 32;
    localparam int IW = 16;
    localparam int PW = 18;
    localparam int SW = 8;
    localparam int AW = 4;
    localparam int MD = 4;
    localparam int EW = 1 + KW + SW + AW + PW;
    localparam int CW = $clog2(MD + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [KW-1:0] in_key = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic          out_hit, out_overflow;
    logic [SW-1:0] out_state;
    logic [AW-1:0] out_action;
    logic [CW-1:0] out_reads;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b0;
    logic          mem_req_write;
    logic [PW-1:0] mem_req_addr;
    logic [EW-1:0] mem_req_wdata;
    logic          mem_rsp_valid = 1'b0;
    logic [EW-1:0] mem_rsp_rdata = '0;

    always #4 clk = ~clk;

    session_lookup #(
        .KEY_W(KW), .IDX_W(IW), .PTR_W(PW), .STATE_W(SW), .ACT_W(AW), .MAX_DEPTH(MD)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_key(in_key),
        .out_valid(out_valid), .out_ready(out_ready), .out_hit(out_hit),
        .out_overflow(out_overflow), .out_state(out_state), .out_action(out_action),
        .out_reads(out_reads),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [EW-1:0] mem [int];
    logic [PW+EW-1:0] wr_log [$];
    int cyc = 0;
    bit pend = 0;
    int pend_cnt = 0;
    int pend_addr = 0;

    function automatic logic [EW-1:0] rd(input int a);
        if (mem.exists(a)) return mem[a];
        return '0;
    endfunction

    always @(posedge clk) begin
        cyc++;
        mem_rsp_valid <= 1'b0;
        if (pend) begin
            if (pend_cnt <= 1) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_rdata <= rd(pend_addr);
                pend = 0;
            end else pend_cnt--;
        end
        if (rst_n && mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                mem[int'(mem_req_addr)] = mem_req_wdata;
                wr_log.push_back({mem_req_addr, mem_req_wdata});
            end else begin
                pend = 1;
                pend_addr = int'(mem_req_addr);
                pend_cnt = 1 + (cyc % 4);
            end
        end
        mem_req_ready <= (cyc % 3) != 1;
    end

    // ---------------- reference functions ----------------
    function automatic logic [31:0] ref_crc(input logic [KW-1:0] k);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < KW; i++) begin
            if (c[0] ^ k[i]) c = (c >> 1) ^ 32'hEDB88320;
            else             c = c >> 1;
        end
        return ~c;
    endfunction

    function automatic int bucket(input logic [KW-1:0] k);
        logic [31:0] c = ref_crc(k);
        return int'(c[IW-1:0]);
    endfunction

    function automatic logic [EW-1:0] mk(input bit v, input logic [KW-1:0] k,
                                         input logic [SW-1:0] s, input logic [AW-1:0] a,
                                         input int nxt);
        logic [PW-1:0] n = PW'(nxt);
        return {v, k, s, a, n};
    endfunction

    bit            e_hit, e_ovf;
    logic [SW-1:0] e_state;
    logic [AW-1:0] e_act;
    int            e_reads;
    int            e_waddr;
    logic [EW-1:0] e_wdata;
    bit            armed = 0;

    task automatic ref_walk(input logic [KW-1:0] k);
        int p = bucket(k);
        logic [EW-1:0] w;
        e_hit = 0; e_ovf = 0; e_state = '0; e_act = '0; e_reads = 0;
        forever begin
            e_reads++;
            w = rd(p);
            if (w[EW-1] && w[PW+AW+SW +: KW] == k) begin
                e_hit   = 1;
                e_state = w[PW+AW +: SW];
                e_act   = w[PW +: AW];
                e_waddr = p;
                e_wdata = w;
                e_wdata[PW+AW +: SW] = (&e_state) ? e_state : e_state + 1'b1;
                break;
            end
            if (!w[EW-1] || w[PW-1:0] == '0) break;
            if (e_reads == MD) begin e_ovf = 1; break; end
            p = int'(w[PW-1:0]);
        end
    endtask

    // per-clock comparison against the reference while a lookup is in flight (R8, R3, R6, R7)
    always @(negedge clk) begin
        if (armed) begin
            chk(in_ready == 1'b0, "R8", "in_ready while busy", 64'(in_ready), 64'd0);
            if (out_valid) begin
                chk(out_hit == e_hit, e_hit ? "R3" : "R6", "out_hit", 64'(out_hit), 64'(e_hit));
                chk(out_overflow == e_ovf, "R7", "out_overflow", 64'(out_overflow), 64'(e_ovf));
                chk(out_state == e_state, "R3", "out_state", 64'(out_state), 64'(e_state));
                chk(out_action == e_act, "R3", "out_action", 64'(out_action), 64'(e_act));
                chk(int'(out_reads) == e_reads, "R5", "out_reads", 64'(out_reads), 64'(e_reads));
            end
        end
    end

    // first read address per lookup (R1)
    bit first_rd = 0;
    int first_exp = 0;
    always @(negedge clk) begin
        if (first_rd && mem_req_valid) begin
            chk(int'(mem_req_addr) == first_exp && !mem_req_write, "R1", "first read address",
                64'(mem_req_addr), 64'(first_exp));
            first_rd = 0;
        end
    end

    task automatic lookup(input logic [KW-1:0] k, input int hold);
        logic [PW+EW-1:0] wr;
        ref_walk(k);
        wr_log.delete();
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        first_exp = bucket(k);
        first_rd  = 1;
        in_valid  = 1'b1;
        in_key    = k;
        @(negedge clk);
        in_valid = 1'b0;
        armed    = 1;
        while (!out_valid) @(negedge clk);
        repeat (hold) @(negedge clk);
        out_ready = 1'b1;
        armed     = 0;
        @(negedge clk);
        out_ready = 1'b0;
        chk(out_valid == 1'b0, "R8", "result released", 64'(out_valid), 64'd0);
        if (e_hit) begin
            chk(wr_log.size() == 1, "R4", "write count on hit", 64'(wr_log.size()), 64'd1);
            if (wr_log.size() == 1) begin
                wr = wr_log[0];
                chk(int'(wr[PW+EW-1:EW]) == e_waddr, "R4", "write address",
                    64'(wr[PW+EW-1:EW]), 64'(e_waddr));
                chk(wr[EW-1:0] == e_wdata, "R4", "write data", 64'(wr[EW-1:0]), 64'(e_wdata));
            end
        end else begin
            chk(wr_log.size() == 0, e_ovf ? "R7" : "R6", "write count on miss",
                64'(wr_log.size()), 64'd0);
        end
    endtask

    // watchdog
    int wd = 0;
    always @(negedge clk) begin
        wd++;
        if (wd > 100000) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=<100000", wd);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    localparam logic [KW-1:0] KA = 32'h0A00_0001;
    localparam logic [KW-1:0] KB = 32'hC0A8_1234;
    localparam logic [KW-1:0] KC = 32'h1111_2222;
    localparam logic [KW-1:0] KD = 32'h3333_4444;
    localparam logic [KW-1:0] KE = 32'h5555_6666;
    localparam logic [KW-1:0] KF = 32'h7777_8888;
    localparam logic [KW-1:0] KG = 32'h9999_AAAA;
    localparam logic [KW-1:0] KH = 32'hBBBB_CCCC;
    localparam int CH = 32'h10000;

    initial begin
        // R2 layout used by mk(): {valid, key, state, action, next}
        mem[bucket(KA)] = mk(1, KA, 8'd5, 4'd3, 0);
        // R5: B sits third in its chain
        mem[bucket(KB)] = mk(1, 32'hDEAD_0001, 8'd1, 4'd1, CH + 0);
        mem[CH + 0]     = mk(1, 32'hDEAD_0002, 8'd2, 4'd2, CH + 1);
        mem[CH + 1]     = mk(1, KB, 8'd40, 4'd9, 0);
        // KC: bucket absent (invalid)
        // KD: two-entry chain ending without a match
        mem[bucket(KD)] = mk(1, 32'hDEAD_0003, 8'd0, 4'd0, CH + 2);
        mem[CH + 2]     = mk(1, 32'hDEAD_0004, 8'd0, 4'd0, 0);
        // KE: six non-matching links
        mem[bucket(KE)] = mk(1, 32'hBEEF_0000, 8'd0, 4'd0, CH + 10);
        for (int i = 0; i < 5; i++)
            mem[CH + 10 + i] = mk(1, 32'hBEEF_0001 + i, 8'd0, 4'd0, (i == 4) ? 0 : CH + 11 + i);
        // KF: match on exactly the MD-th read
        mem[bucket(KF)] = mk(1, 32'hFACE_0000, 8'd0, 4'd0, CH + 20);
        mem[CH + 20]    = mk(1, 32'hFACE_0001, 8'd0, 4'd0, CH + 21);
        mem[CH + 21]    = mk(1, 32'hFACE_0002, 8'd0, 4'd0, CH + 22);
        mem[CH + 22]    = mk(1, KF, 8'd77, 4'd6, 0);
        // KG: saturated state
        mem[bucket(KG)] = mk(1, KG, 8'hFF, 4'd15, 0);
        // KH: invalid head that still carries a pointer
        mem[bucket(KH)] = mk(0, KH, 8'd9, 4'd9, CH + 30);
        mem[CH + 30]    = mk(1, KH, 8'd9, 4'd9, 0);

        repeat (3) @(negedge clk);
        // R10 reset state
        chk(in_ready == 1'b1, "R10", "in_ready in reset", 64'(in_ready), 64'd1);
        chk(out_valid == 1'b0, "R10", "out_valid in reset", 64'(out_valid), 64'd0);
        chk(mem_req_valid == 1'b0, "R10", "mem_req_valid in reset", 64'(mem_req_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R10", "state after reset",
            64'({in_ready, out_valid}), 64'b10);

        lookup(KA, 0);   // R1 R3 R4 head hit
        lookup(KB, 2);   // R5 chain hit
        lookup(KC, 0);   // R6 empty bucket
        lookup(KD, 1);   // R6 end of chain
        lookup(KE, 0);   // R7 overflow
        lookup(KF, 0);   // R7 boundary: hit on last permitted read
        lookup(KG, 0);   // R4 saturation
        lookup(KH, 0);   // R6 invalid head stops the walk
        lookup(KA, 7);   // R4 write-back seen, R8 long hold
        lookup(KB, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule